// File: doc/BRIEF.md
# Time-Shared Symmetric Low-Pass FIR

This block is a 52-tap linear-phase low-pass FIR filter for a slow sample stream whose processing clock runs far faster than the data. One input sample arrives with a one-cycle strobe roughly every 48 clocks. Instead of one multiplier per coefficient, the filter keeps the recent samples in a small circular memory. It then walks the 26 mirrored tap pairs one per clock: the two samples of each pair are added first, and the sum is multiplied by the shared coefficient on the only multiplier in the design.

The products are accumulated in a wide register. The total is rounded and clipped to 16 bits and presented with a single-cycle output strobe a fixed 29 clocks after the input was accepted, well before the next sample is due. The coefficients are fixed constants: pair k (k = 0 outermost) uses 3·(k+1)², which gives a smooth window peaking at the centre pair. Typical use is as the channel filter after a mixer and decimator, where the sample period leaves dozens of idle clocks.

Top module: `tsm_fir_lowpass`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: Every accepted input strobe produces exactly one out_valid pulse, one cycle wide, exactly 29 clocks after the strobe cycle, with no pulse before then. The next strobe is accepted as early as the cycle in which that pulse is visible.
- R3: Let x[0] be the newest accepted sample and x[51] the oldest. The output is round(Σ_k c_k·(x[k] + x[51−k]) / 2^15) for pair index k = 0..25, where c_k = 3·(k+1)².
- R4: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15. For example, an accumulated 16383 gives 0, 16386 gives 1, −16383 gives 0 and −16386 gives −1.
- R5: Results above 32767 are output as 32767, and results below −32768 are output as −32768.
- R6: Tap positions older than the number of samples accepted since the last reset count as zero.
- R7: A strobe that arrives from the accepting cycle up to and including the cycle before the output pulse is visible is ignored. It produces no output and never enters the sample history.
- R8: out_data holds its value on every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | 16 | Signed input sample, taken when in_valid is accepted |
| out_valid | output | 1 | One-cycle strobe marking a new filtered result |
| out_data | output | 16 | Signed, rounded and saturated filter result |

## Verification
Some properties are checked on every cycle. The checker keeps its own model of which strobes are accepted and confirms that each one yields a single pulse exactly at the fixed latency and never elsewhere, which also exposes a stray strobe that slipped into the pipeline. It also confirms that the output holds between pulses and that the reset values appear. The arithmetic can only be shown by the bench scenarios, which compare each result bit-exactly with a direct-form sum: tap ordering through an impulse walk, partial history after reset, rounding just below and above one half in both signs, saturation at both rails, back-to-back strobes, and stray strobes at several points in the busy window, including its very last cycle.

// File: rtl/tsmf_pkg.sv
`timescale 1ns/1ps
package tsmf_pkg;
  // Coefficient of mirrored tap pair k (k = 0 is the outermost pair).
  function automatic int pair_coef(input int k);
    return 3 * (k + 1) * (k + 1);
  endfunction
endpackage

// File: rtl/tsmf_tap_ram.sv
`timescale 1ns/1ps
// Circular sample history: one write port, two registered read ports.
module tsmf_tap_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 52,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr_a,
  input  logic [ADDR_W-1:0]        raddr_b,
  output logic signed [DATA_W-1:0] rdata_a,
  output logic signed [DATA_W-1:0] rdata_b
);
  logic signed [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/tsmf_seq.sv
`timescale 1ns/1ps
// Accepts strobes, stores samples and issues one mirrored pair address per clock.
module tsmf_seq #(
  parameter int NTAPS  = 52,
  parameter int ADDR_W = $clog2(NTAPS),
  parameter int KW     = $clog2(NTAPS / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              done,
  output logic              accept,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] raddr_a,
  output logic [ADDR_W-1:0] raddr_b,
  output logic              rd_v,
  output logic [KW-1:0]     rd_k,
  output logic              rd_first,
  output logic              rd_last,
  output logic              rd_ma,
  output logic              rd_mb
);
  localparam int NPAIR = NTAPS / 2;
  localparam int FW    = ADDR_W + 1;

  logic              busy, run;
  logic [KW-1:0]     k;
  logic [ADDR_W-1:0] base;
  logic [FW-1:0]     fill;
  logic [FW-1:0]     k_ext, mirror;

  // Address of the sample 'off' positions older than the newest one.
  function automatic logic [ADDR_W-1:0] back(input logic [ADDR_W-1:0] b,
                                             input logic [FW-1:0] off);
    logic [FW-1:0] t;
    t = FW'(b) + FW'(NTAPS) - off;
    if (t >= FW'(NTAPS)) t = t - FW'(NTAPS);
    return t[ADDR_W-1:0];
  endfunction

  assign accept = in_valid && !busy;
  assign k_ext  = FW'(k);
  assign mirror = FW'(NTAPS - 1) - k_ext;

  always_comb begin
    raddr_a = back(base, k_ext);
    raddr_b = back(base, mirror);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      run  <= 1'b0;
      k    <= '0;
      base <= '0;
      wptr <= '0;
      fill <= '0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        run  <= 1'b1;
        k    <= '0;
        base <= wptr;
        wptr <= (wptr == ADDR_W'(NTAPS - 1)) ? '0 : wptr + 1'b1;
        if (fill != FW'(NTAPS)) fill <= fill + 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (run) begin
        k <= k + 1'b1;
        if (k == KW'(NPAIR - 1)) run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v     <= 1'b0;
      rd_k     <= '0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
      rd_ma    <= 1'b0;
      rd_mb    <= 1'b0;
    end else begin
      rd_v     <= run;
      rd_k     <= k;
      rd_first <= run && (k == '0);
      rd_last  <= run && (k == KW'(NPAIR - 1));
      rd_ma    <= k_ext < fill;
      rd_mb    <= mirror < fill;
    end
  end
endmodule

// File: rtl/tsmf_mac.sv
`timescale 1ns/1ps
// Pre-add of a mirrored pair, the single shared multiplier, and the accumulator.
module tsmf_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int KW     = 5,
  parameter int PROD_W = DATA_W + 1 + COEF_W,
  parameter int ACC_W  = PROD_W + 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_v,
  input  logic [KW-1:0]            rd_k,
  input  logic                     rd_first,
  input  logic                     rd_last,
  input  logic                     rd_ma,
  input  logic                     rd_mb,
  input  logic signed [DATA_W-1:0] rdata_a,
  input  logic signed [DATA_W-1:0] rdata_b,
  output logic signed [ACC_W-1:0]  acc,
  output logic                     acc_done
);
  logic signed [DATA_W-1:0] a, b;
  logic signed [DATA_W:0]   sum;
  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod;
  logic                     p_v, p_first, p_last;

  always_comb begin
    a    = rd_ma ? rdata_a : '0;
    b    = rd_mb ? rdata_b : '0;
    sum  = (DATA_W + 1)'(a) + (DATA_W + 1)'(b);
    coef = COEF_W'(tsmf_pkg::pair_coef(int'(rd_k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_v      <= 1'b0;
      p_first  <= 1'b0;
      p_last   <= 1'b0;
      prod     <= '0;
      acc      <= '0;
      acc_done <= 1'b0;
    end else begin
      p_v     <= rd_v;
      p_first <= rd_first;
      p_last  <= rd_last;
      prod    <= PROD_W'(sum) * PROD_W'(coef);
      if (p_v) acc <= p_first ? ACC_W'(prod) : acc + ACC_W'(prod);
      acc_done <= p_v && p_last;
    end
  end
endmodule

// File: rtl/tsmf_round_sat.sv
`timescale 1ns/1ps
// Round half up, drop the fraction bits and clip to the output width.
module tsmf_round_sat #(
  parameter int ACC_W  = 39,
  parameter int DATA_W = 16,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_done,
  input  logic signed [ACC_W-1:0]  acc,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam logic signed [ACC_W-1:0] HI   = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO   = -HI - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC - 1));

  logic signed [ACC_W-1:0] rnd, shifted;

  always_comb begin
    rnd     = acc + HALF;
    shifted = rnd >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= acc_done;
      if (acc_done) begin
        if (shifted > HI)      out_data <= HI[DATA_W-1:0];
        else if (shifted < LO) out_data <= LO[DATA_W-1:0];
        else                   out_data <= shifted[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tsm_fir_lowpass.sv
`timescale 1ns/1ps
module tsm_fir_lowpass #(
  parameter int DATA_W            = 16,
  parameter int NTAPS             = 52,
  parameter int COEF_W            = 16,
  parameter int FRAC              = 15,
  parameter int CYCLES_PER_SAMPLE = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int NPAIR   = NTAPS / 2;
  localparam int ADDR_W  = $clog2(NTAPS);
  localparam int KW      = $clog2(NPAIR);
  localparam int PROD_W  = DATA_W + 1 + COEF_W;
  localparam int ACC_W   = PROD_W + $clog2(NPAIR) + 1;
  localparam int LATENCY = NPAIR + 3;

  logic                     accept, done;
  logic [ADDR_W-1:0]        wptr, raddr_a, raddr_b;
  logic                     rd_v, rd_first, rd_last, rd_ma, rd_mb;
  logic [KW-1:0]            rd_k;
  logic signed [DATA_W-1:0] rdata_a, rdata_b;
  logic signed [ACC_W-1:0]  acc;

  tsmf_seq #(.NTAPS(NTAPS), .ADDR_W(ADDR_W), .KW(KW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .done(done), .accept(accept),
    .wptr(wptr), .raddr_a(raddr_a), .raddr_b(raddr_b), .rd_v(rd_v), .rd_k(rd_k),
    .rd_first(rd_first), .rd_last(rd_last), .rd_ma(rd_ma), .rd_mb(rd_mb)
  );

  tsmf_tap_ram #(.DATA_W(DATA_W), .DEPTH(NTAPS), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(accept), .waddr(wptr), .wdata(in_data),
    .raddr_a(raddr_a), .raddr_b(raddr_b), .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  tsmf_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .KW(KW), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .rd_v(rd_v), .rd_k(rd_k), .rd_first(rd_first),
    .rd_last(rd_last), .rd_ma(rd_ma), .rd_mb(rd_mb), .rdata_a(rdata_a),
    .rdata_b(rdata_b), .acc(acc), .acc_done(done)
  );

  tsmf_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC(FRAC)) u_out (
    .clk(clk), .rst(rst), .acc_done(done), .acc(acc),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/tsmf_checker.sv
`timescale 1ns/1ps
module tsmf_checker #(
  parameter int DATA_W = 16,
  parameter int LAT    = 29
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_data
);
  localparam int CW = $clog2(LAT + 2);

  // Independent model of strobe acceptance: one job in flight at a time.
  logic          pending;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (in_valid && (!pending || cnt == CW'(LAT))) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (pending) begin
      if (cnt == CW'(LAT)) pending <= 1'b0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // A stray strobe taken during a job (R7) would give an unmodelled pulse here.
  assert_pulse_when_due_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending && cnt == CW'(LAT)));

  assert_pulse_not_missed_R2: assert property (@(posedge clk) disable iff (rst)
    (pending && cnt == CW'(LAT)) |-> out_valid);

  assert_single_cycle_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_output_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind tsm_fir_lowpass tsmf_checker #(.DATA_W(DATA_W), .LAT(LATENCY)) u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_tsm_fir_lowpass.sv
`timescale 1ns/1ps
module test_tsm_fir_lowpass;
  localparam int LAT = 29;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  int  hist [52];
  int  lcg = 12345;

  always #4 clk = ~clk;

  tsm_fir_lowpass i_tsm_fir_lowpass (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Direct-form reference with the pair coefficients 3*(k+1)^2.
  function automatic int model();
    longint acc = 0;
    longint r;
    for (int k = 0; k < 26; k++)
      acc += longint'(3 * (k + 1) * (k + 1)) * longint'(hist[k] + hist[51 - k]);
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < 52; j++) hist[j] = 0;
  endtask

  // Send one sample; optional stray strobe at cycle junk_at (1..LAT); gap idle cycles after.
  task automatic send(input int x, input int junk_at, input int gap, input string tag);
    int exp;
    bit early;
    bit moved;
    logic signed [15:0] held;
    for (int j = 51; j > 0; j--) hist[j] = hist[j - 1];
    hist[0] = x;
    exp = model();
    in_data  = 16'(x);
    in_valid = 1'b1;
    early    = 1'b0;
    for (int i = 1; i <= LAT + 1; i++) begin
      @(negedge clk);
      if (i == junk_at) begin
        in_valid = 1'b1;
        in_data  = 16'sh5a5a;
      end else begin
        in_valid = 1'b0;
      end
      if (i <= LAT) begin
        if (out_valid) early = 1'b1;
      end else begin
        check(out_valid === 1'b1, "R2 pulse at latency", longint'(out_valid), 1);
        check(int'(out_data) == exp, tag, longint'(out_data), exp);
      end
    end
    check(!early, "R2/R7 no pulse before latency", longint'(early), 0);
    if (gap > 0) begin
      held  = out_data;
      moved = 1'b0;
      repeat (gap) begin
        @(negedge clk);
        if (out_valid || out_data != held) moved = 1'b1;
      end
      check(!moved, "R8 output held while idle", longint'(moved), 0);
    end
  endtask

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'hffff;
  endfunction

  initial begin
    do_reset();
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(out_data == 16'sd0, "R1 out_data after reset", longint'(out_data), 0);

    // R6 and R3: impulse walked through every tap position from an empty history.
    send(20000, 0, 18, "R6 partial history impulse");
    for (int n = 0; n < 55; n++) send(0, 0, 18, "R3 impulse tap walk");

    // R4: rounding around one half, both signs (accumulator equals 3*x).
    do_reset(); send(5461, 0, 18, "R4 round 16383 down");
    do_reset(); send(5462, 0, 18, "R4 round 16386 up");
    do_reset(); send(-5461, 0, 18, "R4 round -16383 to zero");
    do_reset(); send(-5462, 0, 18, "R4 round -16386 to -1");

    // R5: full-scale steps push past both rails.
    do_reset();
    for (int n = 0; n < 56; n++) send(32767, 0, 18, "R5 positive saturation");
    for (int n = 0; n < 56; n++) send(-32768, 0, 18, "R5 negative saturation");

    // R3/R7/R2: random samples with stray strobes and back-to-back spacing.
    for (int n = 0; n < 120; n++) begin
      int x;
      int junk;
      int gap;
      x    = next_rand() - 32768;
      junk = (n % 4 == 1) ? 1 + (n % LAT) : ((n % 9 == 2) ? LAT : 0);
      gap  = (n % 7 == 3) ? 0 : 18;
      send(x, junk, gap, (junk != 0) ? "R7 stray strobe ignored" : "R3 random sample");
    end

    // R6: reset mid-stream clears the history seen by the arithmetic.
    do_reset();
    send(-12345, 0, 18, "R6 history cleared by reset");
    send(777, 3, 18, "R6 second sample after reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule